// File: doc/BRIEF.md
# Microframe Index Counter

This block keeps the 14-bit microframe index of a host controller's periodic schedule. Each microframe of 125 microseconds is announced by a one-clock pulse on `uframe_tick`. While the controller runs, the index steps by one on each pulse.

The block takes the periodic list entry pointer from the upper index bits. Bits [2:0] count the eight microframes spent on one entry, so every entry stays selected for eight consecutive microframes. The highest pointer bit depends on the configured list length.

Software reaches the index through a 32-bit word register. A write takes effect only when all four byte lanes are enabled and the controller reports halted. Any other write leaves the index unchanged. The block also presents a start-of-frame number, the index with its three microframe bits dropped. A write therefore moves that number too.

There is no streaming data path. All pins are plain control and status levels.

Top module: `mfidx_counter`

## Requirements
- R1: After reset, `frame_index`, `list_entry`, `sof_frame` and `reg_rdata` are all zero.
- R2: When `uframe_tick` and `run` are both 1 and no write is accepted, `frame_index` holds its old value plus one from the next clock onward.
- R3: With no accepted write, the index does not change in a cycle where `uframe_tick` is 0 or `run` is 0.
- R4: Stepping from 0x3FFF gives 0x0000. Counting then continues from zero.
- R5: `list_entry` is a zero-extended 10-bit pointer that depends on `list_size`:
  - 2'b00 and 2'b11 give index bits [12:3] (1024 entries).
  - 2'b01 gives bits [11:3] (512 entries).
  - 2'b10 gives bits [10:3] (256 entries).
- R6: A write is accepted when three conditions hold in the same cycle:
  - `reg_wr` is 1;
  - `reg_be` is 4'b1111;
  - `halted` is 1.
  An accepted write loads `reg_wdata[13:0]` into the index from the next clock onward. `reg_wdata[31:14]` is discarded.
- R7: A write with `halted` at 0 has no effect on the index.
- R8: A write with `reg_be` other than 4'b1111 has no effect on the index.
- R9: `reg_rdata` always shows the index in bits [13:0] and zero in bits [31:14].
- R10: `sof_frame` always equals `frame_index[13:3]`, including right after an accepted write.
- R11: When an accepted write and a counting tick occur in the same cycle, the written value is loaded and the tick is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Controller run bit; counting is enabled while 1 |
| halted | input | 1 | Controller halted status; writes are allowed while 1 |
| uframe_tick | input | 1 | One-clock pulse at each microframe end |
| list_size | input | 2 | Periodic list length select |
| reg_wr | input | 1 | Register write strobe |
| reg_be | input | 4 | Byte-lane enables of the write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data |
| frame_index | output | 14 | Current microframe index |
| list_entry | output | 10 | Periodic list entry pointer |
| sof_frame | output | 11 | Start-of-frame number |

## Verification
The hardest condition to reach from the ports is the wrap from 0x3FFF to zero. Counting there from reset would take 16383 ticks.

The stimulus gets there quickly. It halts the controller and loads a value a few steps below the top with a full-word write. It then runs with ticks so the index crosses the wrap. The same preload method places the index at pointer boundaries, where each list size gives a different `list_entry`.

The clash between an accepted write and a counting tick is provoked by asserting `run` and `halted` together. This combination is never produced by a normal controller.

// File: rtl/mfidx_pkg.sv
package mfidx_pkg;
  localparam int unsigned SUB_BITS = 3;
  localparam int unsigned BE_ALL   = 4;

  typedef enum logic [1:0] {
    LS_1024 = 2'b00,
    LS_512  = 2'b01,
    LS_256  = 2'b10,
    LS_RSVD = 2'b11
  } list_size_e;
endpackage

// File: rtl/mfidx_wr_gate.sv
module mfidx_wr_gate #(
  parameter int unsigned BE_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [BE_W-1:0] reg_be,
  input  logic            halted,
  output logic            wr_ok
);
  assign wr_ok = reg_wr && (&reg_be) && halted;

  // R7: writes while running never pass
  a_r7_no_write_running: assert property (@(posedge clk) disable iff (!rst_n)
    !halted |-> !wr_ok);
  // R8: only full-word writes pass
  a_r8_full_word_only: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |-> (reg_be == {BE_W{1'b1}}));
endmodule

// File: rtl/mfidx_core.sv
module mfidx_core #(
  parameter int unsigned IDX_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             load,
  input  logic [IDX_W-1:0] load_val,
  output logic [IDX_W-1:0] idx
);
  always_ff @(posedge clk) begin
    if (!rst_n)    idx <= '0;
    else if (load) idx <= load_val;
    else if (step) idx <= idx + 1'b1;
  end

  // R2, R4: a step adds one modulo 2**IDX_W
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (idx == IDX_W'($past(idx) + 1'b1)));
  // R3: no step and no load keeps the index
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> $stable(idx));
  // R6, R11: a load wins and lands next cycle
  a_r6_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (idx == $past(load_val)));
endmodule

// File: rtl/mfidx_entry_sel.sv
module mfidx_entry_sel
  import mfidx_pkg::*;
#(
  parameter int unsigned IDX_W = 14,
  parameter int unsigned ENT_W = 10
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [1:0]       size,
  output logic [ENT_W-1:0] entry
);
  localparam int unsigned NUM_SZ = 3;

  logic [ENT_W-1:0] cand [NUM_SZ];

  for (genvar g = 0; g < NUM_SZ; g++) begin : g_sz
    assign cand[g] = ENT_W'(idx[SUB_BITS+ENT_W-1-g:SUB_BITS]);
  end

  always_comb begin
    case (size)
      LS_512:  entry = cand[1];
      LS_256:  entry = cand[2];
      default: entry = cand[0];
    endcase
  end
endmodule

// File: rtl/mfidx_counter.sv
module mfidx_counter
  import mfidx_pkg::*;
#(
  parameter int unsigned IDX_W  = 14,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned BE_W  = DATA_W / 8,
  localparam int unsigned ENT_W = IDX_W - 4,
  localparam int unsigned SOF_W = IDX_W - SUB_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              halted,
  input  logic              uframe_tick,
  input  logic [1:0]        list_size,
  input  logic              reg_wr,
  input  logic [BE_W-1:0]   reg_be,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [IDX_W-1:0]  frame_index,
  output logic [ENT_W-1:0]  list_entry,
  output logic [SOF_W-1:0]  sof_frame
);
  logic wr_ok;

  mfidx_wr_gate #(.BE_W(BE_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_be(reg_be),
    .halted(halted), .wr_ok(wr_ok)
  );

  mfidx_core #(.IDX_W(IDX_W)) u_core (
    .clk(clk), .rst_n(rst_n), .step(uframe_tick && run), .load(wr_ok),
    .load_val(reg_wdata[IDX_W-1:0]), .idx(frame_index)
  );

  mfidx_entry_sel #(.IDX_W(IDX_W), .ENT_W(ENT_W)) u_sel (
    .idx(frame_index), .size(list_size), .entry(list_entry)
  );

  assign sof_frame = frame_index[IDX_W-1:SUB_BITS];
  assign reg_rdata = DATA_W'(frame_index);

  // R5: smallest list leaves the two top pointer bits clear
  a_r5_small_list: assert property (@(posedge clk) disable iff (!rst_n)
    (list_size == LS_256) |-> (list_entry[ENT_W-1 -: 2] == 2'b00));
  // R9: reserved read bits stay zero
  a_r9_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[DATA_W-1:IDX_W] == '0);
  // R7: a running controller cannot disturb the index by writing
  a_r7_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && !(uframe_tick && run)) |=> $stable(frame_index));
endmodule

// File: tb/mfidx_counter_test.sv
module mfidx_counter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0, halted = 1'b1, uframe_tick = 1'b0, reg_wr = 1'b0;
  logic [1:0]  list_size = 2'b00;
  logic [3:0]  reg_be = 4'h0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [13:0] frame_index;
  logic [9:0]  list_entry;
  logic [10:0] sof_frame;

  int errors = 0, checks = 0;
  int m_idx = 0;
  string phase = "R1";
  bit checking = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  mfidx_counter uut (
    .clk(clk), .rst_n(rst_n), .run(run), .halted(halted),
    .uframe_tick(uframe_tick), .list_size(list_size), .reg_wr(reg_wr),
    .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .frame_index(frame_index), .list_entry(list_entry), .sof_frame(sof_frame)
  );

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, got, exp, $time);
    end
  endtask

  // behavioural reference
  always @(posedge clk) begin
    if (!rst_n) m_idx <= 0;
    else if (reg_wr && reg_be == 4'hF && halted) m_idx <= int'(reg_wdata) & 32'h3FFF;
    else if (uframe_tick && run) m_idx <= (m_idx + 1) % 16384;
  end

  function automatic int exp_entry(int idx, logic [1:0] sz);
    case (sz)
      2'b01:   return (idx >> 3) & 511;
      2'b10:   return (idx >> 3) & 255;
      default: return (idx >> 3) & 1023;
    endcase
  endfunction

  always @(negedge clk) if (checking) begin
    chk(phase, int'(frame_index), m_idx);
    chk("R5", int'(list_entry), exp_entry(m_idx, list_size));
    chk("R10", int'(sof_frame), m_idx >> 3);
    chk("R9", int'(reg_rdata), m_idx);
  end

  task automatic cyc(logic wr, logic [3:0] be, logic [31:0] d, logic tk);
    @(posedge clk); #1;
    reg_wr = wr; reg_be = be; reg_wdata = d; uframe_tick = tk;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      cyc(1'b0, 4'h0, 32'h0, 1'b1);
      cyc(1'b0, 4'h0, 32'h0, 1'b0);
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: got hang expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1", int'(frame_index), 0);
    chk("R1", int'(list_entry), 0);
    chk("R1", int'(sof_frame), 0);
    chk("R1", int'(reg_rdata), 0);
    checking = 1'b1;

    phase = "R3"; halted = 1'b0; run = 1'b0;
    ticks(3);                               // ticks without run
    phase = "R2"; run = 1'b1;
    ticks(20);
    phase = "R3"; cyc(1'b0, 4'h0, 0, 1'b0); cyc(1'b0, 4'h0, 0, 1'b0);
    phase = "R7"; cyc(1'b1, 4'hF, 32'h0000_1234, 1'b0);
    cyc(1'b0, 4'h0, 0, 1'b0);
    phase = "R6"; run = 1'b0; halted = 1'b1;
    cyc(1'b1, 4'hF, 32'hFFFF_1A5D, 1'b0);   // upper bits discarded
    cyc(1'b0, 4'h0, 0, 1'b0);
    phase = "R8";
    cyc(1'b1, 4'h7, 32'h0000_0111, 1'b0);
    cyc(1'b1, 4'h1, 32'h0000_0222, 1'b0);
    cyc(1'b1, 4'h8, 32'h0000_0333, 1'b0);
    cyc(1'b0, 4'h0, 0, 1'b0);
    phase = "R5";
    for (int s = 0; s < 4; s++) begin
      list_size = 2'(s);
      cyc(1'b1, 4'hF, 32'h0000_0FF8 + 32'(s * 1024 + 1), 1'b0);
      cyc(1'b0, 4'h0, 0, 1'b0);
      run = 1'b1; halted = 1'b0; ticks(10);
      run = 1'b0; halted = 1'b1;
    end
    phase = "R4"; list_size = 2'b00;
    cyc(1'b1, 4'hF, 32'h0000_3FFA, 1'b0);
    cyc(1'b0, 4'h0, 0, 1'b0);
    run = 1'b1; halted = 1'b0; ticks(12);
    phase = "R11"; halted = 1'b1;
    cyc(1'b1, 4'hF, 32'h0000_0400, 1'b1);
    cyc(1'b0, 4'h0, 0, 1'b0);
    cyc(1'b1, 4'hF, 32'h0000_2007, 1'b1);
    phase = "R2"; halted = 1'b0;
    ticks(4);
    cyc(1'b0, 4'h0, 0, 1'b0);
    @(negedge clk);
    checking = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule